// File: doc/BRIEF.md
# SECDED Hamming Word Codec

This block protects a 32-bit data word with a single-error-correcting, double-error-detecting Hamming code. It holds two independent, purely combinational paths. The encoder turns a raw data word into a 39-bit codeword for storage. The checker takes a codeword read back from storage and returns the repaired data word together with a 2-bit verdict.

Codeword positions are numbered 1 to 39, and position p sits in vector bit p-1. The six Hamming check bits occupy positions 1, 2, 4, 8, 16 and 32. The check bit at position 2^k makes the XOR of every position in 1..38 whose index has bit k set equal to zero. Data bit 0 goes to position 3, and the remaining data bits fill the other non-power-of-two positions up to 38 in ascending order. Position 39 holds an overall parity bit, chosen so that all 39 bits XOR to zero.

The checker forms a 6-bit pointer from the check groups and an odd/even flag from the whole word. From these two values it decides to pass the word, repair one bit, or give up. Storage, error counters and bus access belong to the surrounding design.

Top module: `secded_codec`

## Requirements
- R1: The encoder output places the data as described above. Each check group over positions 1..38 XORs to zero, and the whole 39-bit word XORs to zero.
- R2: A codeword exactly as produced by the encoder gives status 00 on the checker, with the original data word on the data output.
- R3: A codeword with exactly one data position inverted gives status 01, and the data output carries the original, corrected data.
- R4: A codeword with exactly one of the positions 1, 2, 4, 8, 16 or 32 inverted gives status 01, and the data output equals the original data.
- R5: A codeword with only position 39 inverted gives status 01, and the data output equals the original data.
- R6: A codeword with exactly two positions inverted, in any combination, gives status 10.
- R7: The status output never takes the value 11.
- R8: When the status is 10, the data output is the data field of the received codeword, taken without any repair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 32 | Raw data word to encode |
| enc_word_o | output | 39 | Codeword produced from enc_data_i |
| chk_word_i | input | 39 | Codeword read back from storage |
| chk_data_o | output | 32 | Data word after the checker's repair |
| chk_status_o | output | 2 | 00 clean, 01 single error fixed, 10 double error, 11 never driven |

## Verification
The hardest case to reach from the ports is a single inverted check bit. The pointer then names a position that carries no data, so a fault in the flip logic or in the extraction map stays hidden unless data and status are checked together. A similar case is a double error whose two positions XOR to a valid in-range pointer. Such a word looks like a correctable single error except for the even overall parity.

The stimulus therefore encodes several data patterns in the bench and inverts every one of the 39 positions in turn. It then walks every pair of positions on two patterns, so each pointer value, including the parity-only and aliasing cases, reaches the checker.

// File: rtl/secded_pkg.sv
package secded_pkg;

    function automatic int ham_bits(int dw);
        int r;
        r = 0;
        while ((1 << r) < dw + r + 1) r++;
        return r;
    endfunction

    localparam int DATA_W = 32;
    localparam int HAM_W  = ham_bits(DATA_W);
    localparam int POS_N  = DATA_W + HAM_W;
    localparam int CW_W   = POS_N + 1;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_FIXED  = 2'b01,
        ST_DOUBLE = 2'b10,
        ST_RSVD   = 2'b11
    } chk_status_e;

    typedef struct packed {
        logic [HAM_W-1:0] ptr;
        logic             odd;
    } syndrome_t;

    function automatic bit is_pow2(int p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    // data index held at a non-power-of-two position p (1-based)
    function automatic int data_index(int p);
        return p - $clog2(p + 1) - 1;
    endfunction

    // positions 1..POS_N covered by check bit k, bit p-1 <=> position p
    function automatic logic [POS_N-1:0] cover_mask(int k);
        logic [POS_N-1:0] m;
        m = '0;
        for (int p = 1; p <= POS_N; p++)
            if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   word_o
);
    logic [POS_N-1:0] dbody;
    logic [POS_N-1:0] full;

    for (genvar p = 1; p <= POS_N; p++) begin : g_pos
        if (is_pow2(p)) begin : g_chk
            localparam int K = $clog2(p);
            localparam logic [POS_N-1:0] MASK = cover_mask(K);
            assign dbody[p-1] = 1'b0;
            assign full[p-1]  = ^(dbody & MASK);
        end else begin : g_dat
            assign dbody[p-1] = data_i[data_index(p)];
            assign full[p-1]  = dbody[p-1];
        end
    end

    assign word_o = {^full, full};
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  logic [CW_W-1:0] word_i,
    output syndrome_t       syn_o
);
    for (genvar k = 0; k < HAM_W; k++) begin : g_grp
        localparam logic [POS_N-1:0] MASK = cover_mask(k);
        assign syn_o.ptr[k] = ^(word_i[POS_N-1:0] & MASK);
    end

    assign syn_o.odd = ^word_i;
endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  logic [CW_W-1:0]   word_i,
    input  syndrome_t         syn_i,
    output logic [DATA_W-1:0] data_o,
    output chk_status_e       status_o
);
    logic [POS_N-1:0] fixed;

    always_comb begin
        fixed    = word_i[POS_N-1:0];
        status_o = ST_CLEAN;
        if (syn_i.odd) begin
            if (syn_i.ptr == '0) begin
                status_o = ST_FIXED;            // only the top parity bit is off
            end else if (syn_i.ptr <= HAM_W'(POS_N)) begin
                status_o = ST_FIXED;
                for (int p = 1; p <= POS_N; p++)
                    if (syn_i.ptr == HAM_W'(p)) fixed[p-1] = ~fixed[p-1];
            end else begin
                status_o = ST_DOUBLE;           // pointer out of range: multi-bit
            end
        end else if (syn_i.ptr != '0) begin
            status_o = ST_DOUBLE;
        end
    end

    for (genvar p = 1; p <= POS_N; p++) begin : g_out
        if (!is_pow2(p)) begin : g_dat
            assign data_o[data_index(p)] = fixed[p-1];
        end
    end
endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic [31:0] enc_data_i,
    output logic [38:0] enc_word_o,
    input  logic [38:0] chk_word_i,
    output logic [31:0] chk_data_o,
    output logic [1:0]  chk_status_o
);
    syndrome_t   syn;
    chk_status_e status;

    secded_encoder u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_o)
    );

    secded_syndrome u_syn (
        .word_i (chk_word_i),
        .syn_o  (syn)
    );

    secded_corrector u_cor (
        .word_i   (chk_word_i),
        .syn_i    (syn),
        .data_o   (chk_data_o),
        .status_o (status)
    );

    assign chk_status_o = status;
endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
(
    input logic [31:0] enc_data_i,
    input logic [38:0] enc_word_o,
    input logic [38:0] chk_word_i,
    input logic [31:0] chk_data_o,
    input logic [1:0]  chk_status_o
);
    function automatic logic [DATA_W-1:0] raw_field(logic [CW_W-1:0] w);
        logic [DATA_W-1:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= POS_N; p++)
            if (!is_pow2(p)) begin
                d[j] = w[p-1];
                j++;
            end
        return d;
    endfunction

    always_comb begin
        if (!$isunknown({enc_data_i, enc_word_o})) begin
            assert_enc_even_R1 : assert (^enc_word_o == 1'b0);
        end
        if (!$isunknown({chk_word_i, chk_data_o, chk_status_o})) begin
            assert_no_reserved_R7 : assert (chk_status_o != 2'b11);
            assert_odd_not_clean_R3 : assert (!(^chk_word_i) || chk_status_o != 2'b00);
            assert_even_dirty_double_R6 : assert ((^chk_word_i) || chk_status_o != 2'b01);
            assert_double_raw_R8 : assert (chk_status_o != 2'b10 ||
                                           chk_data_o == raw_field(chk_word_i));
        end
        if (!$isunknown({enc_data_i, enc_word_o, chk_word_i, chk_data_o, chk_status_o})) begin
            assert_round_trip_R2 : assert (chk_word_i != enc_word_o ||
                                           (chk_status_o == 2'b00 && chk_data_o == enc_data_i));
        end
    end
endmodule

bind secded_codec secded_codec_chk u_chk (
    .enc_data_i   (enc_data_i),
    .enc_word_o   (enc_word_o),
    .chk_word_i   (chk_word_i),
    .chk_data_o   (chk_data_o),
    .chk_status_o (chk_status_o)
);

// File: tb/secded_codec_test.sv
module secded_codec_test;
    logic        clk = 1'b0;
    logic [31:0] enc_data_i = '0;
    logic [38:0] enc_word_o;
    logic [38:0] chk_word_i = '0;
    logic [31:0] chk_data_o;
    logic [1:0]  chk_status_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    secded_codec uut (
        .enc_data_i   (enc_data_i),
        .enc_word_o   (enc_word_o),
        .chk_word_i   (chk_word_i),
        .chk_data_o   (chk_data_o),
        .chk_status_o (chk_status_o)
    );

    function automatic bit pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // reference: check bits are the XOR of the indices of all set data positions
    function automatic logic [38:0] ref_encode(logic [31:0] d);
        logic [38:0] w;
        int j;
        int s;
        w = '0;
        j = 0;
        s = 0;
        for (int p = 1; p <= 38; p++) begin
            if (!pow2(p)) begin
                w[p-1] = d[j];
                if (d[j]) s = s ^ p;
                j++;
            end
        end
        for (int k = 0; k < 6; k++) w[(1 << k) - 1] = s[k];
        w[38] = ^w[37:0];
        return w;
    endfunction

    function automatic logic [31:0] ref_field(logic [38:0] w);
        logic [31:0] d;
        int j;
        d = '0;
        j = 0;
        for (int p = 1; p <= 38; p++)
            if (!pow2(p)) begin
                d[j] = w[p-1];
                j++;
            end
        return d;
    endfunction

    task automatic ref_check(input logic [38:0] w_in, output logic [31:0] d, output logic [1:0] st);
        logic [38:0] w;
        int s;
        w = w_in;
        s = 0;
        for (int p = 1; p <= 38; p++) if (w[p-1]) s = s ^ p;
        if (s == 0 && !(^w)) st = 2'b00;
        else if (^w) begin
            if (s == 0) st = 2'b01;
            else if (s <= 38) begin
                st = 2'b01;
                w[s-1] = ~w[s-1];
            end else st = 2'b10;
        end else st = 2'b10;
        d = ref_field(w);
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] d, input logic [38:0] flip, input string req);
        logic [31:0] ed;
        logic [1:0]  es;
        logic [38:0] ew;
        @(posedge clk);
        #2;
        ew         = ref_encode(d);
        enc_data_i = d;
        chk_word_i = ew ^ flip;
        @(negedge clk);
        ref_check(ew ^ flip, ed, es);
        check(enc_word_o == ew, "R1 encode", 64'(enc_word_o), 64'(ew));
        check(chk_status_o == es, {req, " status"}, 64'(chk_status_o), 64'(es));
        check(chk_data_o == ed, {req, " data"}, 64'(chk_data_o), 64'(ed));
        check(chk_status_o != 2'b11, "R7 reserved", 64'(chk_status_o), 64'd0);
        if (flip != '0 && $countones(flip) == 1)
            check(chk_data_o == d, {req, " original data"}, 64'(chk_data_o), 64'(d));
    endtask

    logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
                              32'h0000_00C8, 32'h8000_0001, 32'h1234_5678};

    initial begin
        // idle state: all-zero data encodes to an all-zero word, checker clean
        @(negedge clk);
        check(enc_word_o == '0, "R1 zero word", 64'(enc_word_o), 64'd0);
        check(chk_status_o == 2'b00, "R2 zero status", 64'(chk_status_o), 64'd0);
        for (int i = 0; i < 6; i++) run_case(pats[i], '0, "R2");
        for (int b = 0; b < 32; b++) run_case(32'h1 << b, '0, "R2");
        // every single inversion
        for (int i = 0; i < 6; i++)
            for (int p = 1; p <= 39; p++)
                run_case(pats[i], 39'h1 << (p - 1),
                         p == 39 ? "R5" : (pow2(p) ? "R4" : "R3"));
        // every double inversion on two patterns
        for (int i = 2; i < 4; i++)
            for (int a = 0; a < 39; a++)
                for (int b = a + 1; b < 39; b++) begin
                    run_case(pats[i], (39'h1 << a) | (39'h1 << b), "R6");
                    check(chk_data_o == ref_field(ref_encode(pats[i]) ^ ((39'h1 << a) | (39'h1 << b))),
                          "R8 raw data", 64'(chk_data_o), 64'(0));
                end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule